// File: doc/BRIEF.md
# Flash Command Interface Decoder

This block is the command front end of a byte-wide NOR-flash-style memory model. It oversamples the asynchronous bus strobes with the system clock. It detects the end of each bus write cycle and decodes the byte written, either as a one-cycle command or as the first or second half of a two-cycle command. The decoder chooses what a read returns: array contents, identifier codes or the status byte. It sends program, block erase, chip erase, suspend, resume and lock requests to a separate write/erase engine as a one-cycle strobe that carries an operation kind, an address and a data byte.

Before it issues a program or erase, the block applies the protection rules. It keeps a lock bit per block and a sticky master lock. Boot blocks are also protected whenever the write-protect pin is low. A refused operation never reaches the engine. It only sets error flags in the status byte. The engine itself is represented by a single busy input, which appears as the ready bit of status.

The block index of an address is its top `BLK_W` bits. The lowest `BOOT_BLKS` block indices are the boot blocks.

Top module: `flash_cmd_front`

## Requirements
- R1: The first-cycle bytes FFh, 90h and 70h set `rd_mode` to 0 (array), 1 (identifier) and 2 (status). `rd_mode` never takes the value 3.
- R2: The byte 50h written as a single cycle clears status bits 5, 4, 3 and 1, and it leaves `rd_mode` unchanged.
- R3: Program starts with a setup byte of 40h or 10h, and both are treated the same. The next write cycle then issues a one-cycle `op_valid` with `op_kind`=0, and `op_addr`/`op_data` equal to that cycle's address and data.
- R4: The pair 20h, D0h issues `op_kind`=1 (block erase) at the second cycle's address. The pair 30h, D0h issues `op_kind`=2 (chip erase), but only when no block is effectively locked.
- R5: B0h issues `op_kind`=3 (suspend) and sets status bit 6. D0h as a first-cycle byte issues `op_kind`=4 (resume) and clears status bit 6.
- R6: After the setup byte 60h, a second byte of 01h issues `op_kind`=5 and locks the addressed block. D0h issues `op_kind`=6 and unlocks all blocks. F1h issues `op_kind`=7 and sets the master lock.
- R7: While the master lock is set, 60h/01h is refused and sets status bits 4 and 1, and 60h/D0h is refused and sets status bits 5 and 1. In both cases no operation is issued. Only reset clears the master lock.
- R8: A block is effectively locked if its lock bit is set, or if it is a boot block and `wp_n` is low. A program to a locked block sets status bits 4 and 1, an erase sets status bits 5 and 1, and neither issues an operation.
- R9: A first-cycle byte outside the command set issues no operation and changes neither `rd_mode` nor status.
- R10: A second byte that is not valid after 20h, 30h or 60h issues no operation, sets status bit 3, and returns the decoder to the first-cycle state.
- R11: Address and data are taken from the last clock at which `bus_we_n` and `bus_ce_n` were both low, so whichever strobe rises first ends the cycle. Values on the bus after that are ignored.
- R12: Status bit 7 equals the inverse of `eng_busy`. Every setup, program, erase, suspend, resume or lock command sets `rd_mode` to 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | ADDR_W | Bus address |
| bus_din | input | 8 | Bus write data |
| bus_we_n | input | 1 | Write enable, active low |
| bus_ce_n | input | 1 | Chip enable, active low |
| wp_n | input | 1 | Write protect for boot blocks, active low |
| eng_busy | input | 1 | Engine busy |
| rd_mode | output | 2 | Read source: 0 array, 1 identifier, 2 status |
| op_valid | output | 1 | One-cycle operation request |
| op_kind | output | 3 | Operation kind (0..7, see R3 to R6) |
| op_addr | output | ADDR_W | Operation address |
| op_data | output | 8 | Operation data byte |
| status | output | 8 | Status byte |

## Verification
The embedded properties are checked on every cycle. They cover the following:
- Requests and write-end strobes are single-cycle pulses.
- `rd_mode` never leaves its legal range.
- The master lock never falls.
- A program or erase is never issued while its target, or for chip erase any block, was locked one cycle earlier.
- No lock-bit change is issued while the master lock is set.

Only the bench scenarios can show the rest. This covers the exact byte pairs that are decoded, the status flags raised and cleared by each refusal and by 50h, reserved bytes having no effect, aborted sequences returning to idle, and capture on the strobe that rises first.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [1:0] {
        RM_ARRAY  = 2'd0,
        RM_IDENT  = 2'd1,
        RM_STATUS = 2'd2
    } rd_mode_e;

    typedef enum logic [2:0] {
        OP_PROG   = 3'd0,
        OP_BERASE = 3'd1,
        OP_CERASE = 3'd2,
        OP_SUSP   = 3'd3,
        OP_RESUME = 3'd4,
        OP_LKSET  = 3'd5,
        OP_LKCLR  = 3'd6,
        OP_MASTER = 3'd7
    } op_kind_e;

    typedef enum logic [2:0] {
        SQ_IDLE   = 3'd0,
        SQ_PROG   = 3'd1,
        SQ_BERASE = 3'd2,
        SQ_CERASE = 3'd3,
        SQ_LOCK   = 3'd4
    } seq_state_e;

    localparam logic [7:0] CMD_ARRAY   = 8'hFF;
    localparam logic [7:0] CMD_IDENT   = 8'h90;
    localparam logic [7:0] CMD_STATUS  = 8'h70;
    localparam logic [7:0] CMD_CLRSTS  = 8'h50;
    localparam logic [7:0] CMD_BERASE  = 8'h20;
    localparam logic [7:0] CMD_CERASE  = 8'h30;
    localparam logic [7:0] CMD_PROG_A  = 8'h40;
    localparam logic [7:0] CMD_PROG_B  = 8'h10;
    localparam logic [7:0] CMD_LOCKSU  = 8'h60;
    localparam logic [7:0] CMD_SUSPEND = 8'hB0;
    localparam logic [7:0] CMD_CONFIRM = 8'hD0;
    localparam logic [7:0] CMD_LKBLK   = 8'h01;
    localparam logic [7:0] CMD_LKMAST  = 8'hF1;

endpackage

// File: rtl/flash_bus_capture.sv
module flash_bus_capture #(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_din,
    input  logic              bus_we_n,
    input  logic              bus_ce_n,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data
);

    typedef struct packed {
        logic              act;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d     = cap_q;
        cap_d.act = ~bus_we_n & ~bus_ce_n;
        if (cap_d.act) begin
            cap_d.addr = bus_addr;
            cap_d.data = bus_din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    // End of write: both strobes were low, now at least one is high.
    assign wr_stb  = cap_q.act & ~cap_d.act;
    assign wr_addr = cap_q.addr;
    assign wr_data = cap_q.data;

    // R11
    wr_end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

endmodule

// File: rtl/flash_lock_table.sv
module flash_lock_table #(
    parameter int BLK_W     = 4,
    parameter int BOOT_BLKS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wp_n,
    input  logic                  set_en,
    input  logic [BLK_W-1:0]      set_idx,
    input  logic                  clr_all,
    input  logic                  master_set,
    output logic [(1<<BLK_W)-1:0] eff_lock,
    output logic                  master_q
);

    localparam int NBLK = 1 << BLK_W;

    typedef struct packed {
        logic [NBLK-1:0] bits;
        logic            master;
    } lk_t;

    lk_t lk_d, lk_q;

    always_comb begin
        lk_d = lk_q;
        if (clr_all)    lk_d.bits = '0;
        if (set_en)     lk_d.bits[set_idx] = 1'b1;
        if (master_set) lk_d.master = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lk_q <= '0;
        else        lk_q <= lk_d;
    end

    for (genvar g = 0; g < NBLK; g++) begin : g_eff
        if (g < BOOT_BLKS) begin : g_boot
            assign eff_lock[g] = lk_q.bits[g] | ~wp_n;
        end else begin : g_main
            assign eff_lock[g] = lk_q.bits[g];
        end
    end

    assign master_q = lk_q.master;

    // R7
    master_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(lk_q.master));

    // R7
    no_bitchg_when_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_q.master |=> (lk_q.bits == $past(lk_q.bits)));

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int BLK_W  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_stb,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [7:0]            wr_data,
    input  logic [(1<<BLK_W)-1:0] eff_lock,
    input  logic                  master_q,
    input  logic                  eng_busy,
    output logic                  lk_set,
    output logic [BLK_W-1:0]      lk_idx,
    output logic                  lk_clr,
    output logic                  lk_master,
    output logic [1:0]            rd_mode,
    output logic                  op_valid,
    output logic [2:0]            op_kind,
    output logic [ADDR_W-1:0]     op_addr,
    output logic [7:0]            op_data,
    output logic [7:0]            status
);

    typedef struct packed {
        rd_mode_e          mode;
        seq_state_e        state;
        logic              op_valid;
        op_kind_e          op_kind;
        logic [ADDR_W-1:0] op_addr;
        logic [7:0]        op_data;
        logic              susp;
        logic              e_erase;
        logic              e_prog;
        logic              e_seq;
        logic              e_lock;
    } seq_t;

    seq_t sq_d, sq_q;

    logic [BLK_W-1:0] blk_in;
    logic             tgt_locked;
    logic             any_locked;

    assign blk_in     = wr_addr[ADDR_W-1 -: BLK_W];
    assign tgt_locked = eff_lock[blk_in];
    assign any_locked = |eff_lock;

    always_comb begin
        sq_d          = sq_q;
        sq_d.op_valid = 1'b0;
        lk_set        = 1'b0;
        lk_clr        = 1'b0;
        lk_master     = 1'b0;
        lk_idx        = blk_in;
        if (wr_stb) begin
            sq_d.op_addr = wr_addr;
            sq_d.op_data = wr_data;
            if (sq_q.state == SQ_IDLE) begin
                case (wr_data)
                    CMD_ARRAY:  sq_d.mode = RM_ARRAY;
                    CMD_IDENT:  sq_d.mode = RM_IDENT;
                    CMD_STATUS: sq_d.mode = RM_STATUS;
                    CMD_CLRSTS: begin
                        sq_d.e_erase = 1'b0;
                        sq_d.e_prog  = 1'b0;
                        sq_d.e_seq   = 1'b0;
                        sq_d.e_lock  = 1'b0;
                    end
                    CMD_BERASE: begin
                        sq_d.state = SQ_BERASE;
                        sq_d.mode  = RM_STATUS;
                    end
                    CMD_CERASE: begin
                        sq_d.state = SQ_CERASE;
                        sq_d.mode  = RM_STATUS;
                    end
                    CMD_PROG_A, CMD_PROG_B: begin
                        sq_d.state = SQ_PROG;
                        sq_d.mode  = RM_STATUS;
                    end
                    CMD_LOCKSU: begin
                        sq_d.state = SQ_LOCK;
                        sq_d.mode  = RM_STATUS;
                    end
                    CMD_SUSPEND: begin
                        sq_d.op_valid = 1'b1;
                        sq_d.op_kind  = OP_SUSP;
                        sq_d.susp     = 1'b1;
                        sq_d.mode     = RM_STATUS;
                    end
                    CMD_CONFIRM: begin
                        sq_d.op_valid = 1'b1;
                        sq_d.op_kind  = OP_RESUME;
                        sq_d.susp     = 1'b0;
                        sq_d.mode     = RM_STATUS;
                    end
                    default: ;
                endcase
            end else begin
                sq_d.state = SQ_IDLE;
                sq_d.mode  = RM_STATUS;
                case (sq_q.state)
                    SQ_PROG: begin
                        if (tgt_locked) begin
                            sq_d.e_prog = 1'b1;
                            sq_d.e_lock = 1'b1;
                        end else begin
                            sq_d.op_valid = 1'b1;
                            sq_d.op_kind  = OP_PROG;
                        end
                    end
                    SQ_BERASE: begin
                        if (wr_data != CMD_CONFIRM) begin
                            sq_d.e_seq = 1'b1;
                        end else if (tgt_locked) begin
                            sq_d.e_erase = 1'b1;
                            sq_d.e_lock  = 1'b1;
                        end else begin
                            sq_d.op_valid = 1'b1;
                            sq_d.op_kind  = OP_BERASE;
                        end
                    end
                    SQ_CERASE: begin
                        if (wr_data != CMD_CONFIRM) begin
                            sq_d.e_seq = 1'b1;
                        end else if (any_locked) begin
                            sq_d.e_erase = 1'b1;
                            sq_d.e_lock  = 1'b1;
                        end else begin
                            sq_d.op_valid = 1'b1;
                            sq_d.op_kind  = OP_CERASE;
                        end
                    end
                    SQ_LOCK: begin
                        case (wr_data)
                            CMD_LKBLK: begin
                                if (master_q) begin
                                    sq_d.e_prog = 1'b1;
                                    sq_d.e_lock = 1'b1;
                                end else begin
                                    sq_d.op_valid = 1'b1;
                                    sq_d.op_kind  = OP_LKSET;
                                    lk_set        = 1'b1;
                                end
                            end
                            CMD_CONFIRM: begin
                                if (master_q) begin
                                    sq_d.e_erase = 1'b1;
                                    sq_d.e_lock  = 1'b1;
                                end else begin
                                    sq_d.op_valid = 1'b1;
                                    sq_d.op_kind  = OP_LKCLR;
                                    lk_clr        = 1'b1;
                                end
                            end
                            CMD_LKMAST: begin
                                sq_d.op_valid = 1'b1;
                                sq_d.op_kind  = OP_MASTER;
                                lk_master     = 1'b1;
                            end
                            default: sq_d.e_seq = 1'b1;
                        endcase
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q      <= '0;
            sq_q.mode <= RM_ARRAY;
        end else begin
            sq_q <= sq_d;
        end
    end

    assign rd_mode  = sq_q.mode;
    assign op_valid = sq_q.op_valid;
    assign op_kind  = sq_q.op_kind;
    assign op_addr  = sq_q.op_addr;
    assign op_data  = sq_q.op_data;
    assign status   = {~eng_busy, sq_q.susp, sq_q.e_erase, sq_q.e_prog,
                       sq_q.e_seq, 1'b0, sq_q.e_lock, 1'b0};

    // R3
    op_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sq_q.op_valid |=> !sq_q.op_valid);

    // R1
    mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sq_q.mode != 2'd3);

    // R8
    no_locked_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_q.op_valid && (sq_q.op_kind == OP_PROG || sq_q.op_kind == OP_BERASE))
            |-> !$past(eff_lock[blk_in]));

    // R4
    chip_erase_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_q.op_valid && sq_q.op_kind == OP_CERASE) |-> ($past(eff_lock) == '0));

    // R7
    no_lockop_under_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_q.op_valid && (sq_q.op_kind == OP_LKSET || sq_q.op_kind == OP_LKCLR))
            |-> !$past(master_q));

endmodule

// File: rtl/flash_cmd_front.sv
module flash_cmd_front #(
    parameter int ADDR_W    = 20,
    parameter int BLK_W     = 4,
    parameter int BOOT_BLKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_din,
    input  logic              bus_we_n,
    input  logic              bus_ce_n,
    input  logic              wp_n,
    input  logic              eng_busy,
    output logic [1:0]        rd_mode,
    output logic              op_valid,
    output logic [2:0]        op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [7:0]        op_data,
    output logic [7:0]        status
);

    localparam int NBLK = 1 << BLK_W;

    logic              wr_stb;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;
    logic [NBLK-1:0]   eff_lock;
    logic              master_q;
    logic              lk_set, lk_clr, lk_master;
    logic [BLK_W-1:0]  lk_idx;

    flash_bus_capture #(.ADDR_W(ADDR_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_din  (bus_din),
        .bus_we_n (bus_we_n),
        .bus_ce_n (bus_ce_n),
        .wr_stb   (wr_stb),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    flash_lock_table #(.BLK_W(BLK_W), .BOOT_BLKS(BOOT_BLKS)) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .wp_n       (wp_n),
        .set_en     (lk_set),
        .set_idx    (lk_idx),
        .clr_all    (lk_clr),
        .master_set (lk_master),
        .eff_lock   (eff_lock),
        .master_q   (master_q)
    );

    flash_cmd_seq #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .eff_lock  (eff_lock),
        .master_q  (master_q),
        .eng_busy  (eng_busy),
        .lk_set    (lk_set),
        .lk_idx    (lk_idx),
        .lk_clr    (lk_clr),
        .lk_master (lk_master),
        .rd_mode   (rd_mode),
        .op_valid  (op_valid),
        .op_kind   (op_kind),
        .op_addr   (op_addr),
        .op_data   (op_data),
        .status    (status)
    );

endmodule

// File: tb/sim_flash_cmd_front.sv
module sim_flash_cmd_front;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] bus_addr = '0;
    logic [7:0]  bus_din = '0;
    logic        bus_we_n = 1'b1;
    logic        bus_ce_n = 1'b1;
    logic        wp_n = 1'b1;
    logic        eng_busy = 1'b0;
    logic [1:0]  rd_mode;
    logic        op_valid;
    logic [2:0]  op_kind;
    logic [19:0] op_addr;
    logic [7:0]  op_data;
    logic [7:0]  status;

    always #2 clk = ~clk;

    flash_cmd_front u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_din(bus_din),
        .bus_we_n(bus_we_n), .bus_ce_n(bus_ce_n), .wp_n(wp_n), .eng_busy(eng_busy),
        .rd_mode(rd_mode), .op_valid(op_valid), .op_kind(op_kind),
        .op_addr(op_addr), .op_data(op_data), .status(status)
    );

    int   n_chk = 0;
    int   n_err = 0;
    bit   done  = 0;

    // Reference model state
    int   m_mode, m_pend;
    bit   m_lock [16];
    bit   m_master, m_susp, m_ee, m_ep, m_es, m_el;
    bit   e_valid;
    int   e_kind;
    string e_req;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit eff(input int b);
        return m_lock[b] | (b < 2 && !wp_n);
    endfunction

    function automatic bit any_eff();
        for (int i = 0; i < 16; i++) if (eff(i)) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [7:0] exp_status();
        return {~eng_busy, m_susp, m_ee, m_ep, m_es, 1'b0, m_el, 1'b0};
    endfunction

    task automatic model_reset();
        m_mode = 0; m_pend = 0; m_master = 0; m_susp = 0;
        m_ee = 0; m_ep = 0; m_es = 0; m_el = 0;
        for (int i = 0; i < 16; i++) m_lock[i] = 0;
    endtask

    task automatic model_apply(input logic [19:0] a, input logic [7:0] d);
        int b;
        int p;
        b = int'(a[19:16]);
        e_valid = 0; e_kind = 0;
        if (m_pend == 0) begin
            case (d)
                8'hFF: begin m_mode = 0; e_req = "R1"; end
                8'h90: begin m_mode = 1; e_req = "R1"; end
                8'h70: begin m_mode = 2; e_req = "R1"; end
                8'h50: begin m_ee = 0; m_ep = 0; m_es = 0; m_el = 0; e_req = "R2"; end
                8'h20: begin m_pend = 2; m_mode = 2; e_req = "R4"; end
                8'h30: begin m_pend = 3; m_mode = 2; e_req = "R4"; end
                8'h40, 8'h10: begin m_pend = 1; m_mode = 2; e_req = "R3"; end
                8'h60: begin m_pend = 4; m_mode = 2; e_req = "R6"; end
                8'hB0: begin e_valid = 1; e_kind = 3; m_susp = 1; m_mode = 2; e_req = "R5"; end
                8'hD0: begin e_valid = 1; e_kind = 4; m_susp = 0; m_mode = 2; e_req = "R5"; end
                default: e_req = "R9";
            endcase
        end else begin
            p = m_pend; m_pend = 0; m_mode = 2;
            case (p)
                1: if (eff(b)) begin m_ep = 1; m_el = 1; e_req = "R8"; end
                   else begin e_valid = 1; e_kind = 0; e_req = "R3"; end
                2: if (d != 8'hD0) begin m_es = 1; e_req = "R10"; end
                   else if (eff(b)) begin m_ee = 1; m_el = 1; e_req = "R8"; end
                   else begin e_valid = 1; e_kind = 1; e_req = "R4"; end
                3: if (d != 8'hD0) begin m_es = 1; e_req = "R10"; end
                   else if (any_eff()) begin m_ee = 1; m_el = 1; e_req = "R4"; end
                   else begin e_valid = 1; e_kind = 2; e_req = "R4"; end
                default: begin
                    if (d == 8'h01) begin
                        if (m_master) begin m_ep = 1; m_el = 1; e_req = "R7"; end
                        else begin e_valid = 1; e_kind = 5; m_lock[b] = 1; e_req = "R6"; end
                    end else if (d == 8'hD0) begin
                        if (m_master) begin m_ee = 1; m_el = 1; e_req = "R7"; end
                        else begin
                            e_valid = 1; e_kind = 6; e_req = "R6";
                            for (int i = 0; i < 16; i++) m_lock[i] = 0;
                        end
                    end else if (d == 8'hF1) begin
                        e_valid = 1; e_kind = 7; m_master = 1; e_req = "R6";
                    end else begin
                        m_es = 1; e_req = "R10";
                    end
                end
            endcase
        end
    endtask

    // One bus write; ce_first picks which strobe rises first. After the
    // first strobe rises the bus is scrambled, which must be ignored (R11).
    task automatic do_cmd(input logic [19:0] a, input logic [7:0] d, input bit ce_first);
        model_apply(a, d);
        @(negedge clk);
        bus_addr = a; bus_din = d; bus_we_n = 1'b0; bus_ce_n = 1'b0;
        @(negedge clk);
        if (ce_first) bus_ce_n = 1'b1; else bus_we_n = 1'b1;
        bus_addr = ~a; bus_din = ~d;
        @(negedge clk);
        bus_we_n = 1'b1; bus_ce_n = 1'b1;
        chk(op_valid == e_valid, e_req, "op_valid", int'(op_valid), int'(e_valid));
        if (e_valid && op_valid) begin
            chk(op_kind == 3'(e_kind), e_req, "op_kind", int'(op_kind), e_kind);
            chk(op_addr == a, "R11", "op_addr", int'(op_addr), int'(a));
            if (e_kind == 0)
                chk(op_data == d, "R3", "op_data", int'(op_data), int'(d));
        end
        chk(rd_mode == 2'(m_mode), "R12", "rd_mode", int'(rd_mode), m_mode);
        chk(status == exp_status(), e_req, "status", int'(status), int'(exp_status()));
        @(negedge clk);
        chk(op_valid == 1'b0, "R3", "op_valid pulse", int'(op_valid), 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_we_n = 1'b1; bus_ce_n = 1'b1;
        model_reset();
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    function automatic logic [19:0] rnd_addr(input int blk);
        return {4'(blk), 16'($urandom)};
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        do_reset();

        // Reset state
        chk(rd_mode == 2'd0, "R1", "reset rd_mode", int'(rd_mode), 0);
        chk(status == 8'h80, "R12", "reset status", int'(status), 8'h80);
        chk(op_valid == 1'b0, "R3", "reset op_valid", int'(op_valid), 0);
        eng_busy = 1'b1;
        @(negedge clk);
        chk(status[7] == 1'b0, "R12", "busy ready bit", int'(status[7]), 0);
        eng_busy = 1'b0;

        // Read modes and reserved bytes
        do_cmd(rnd_addr(5), 8'h90, 0);
        do_cmd(rnd_addr(5), 8'h00, 0);   // reserved: stays identifier (R9)
        do_cmd(rnd_addr(5), 8'h70, 1);
        do_cmd(rnd_addr(5), 8'hFF, 0);
        do_cmd(rnd_addr(5), 8'hC3, 1);   // reserved (R9)

        // Program with both setup bytes, captured via each strobe (R3, R11)
        do_cmd(rnd_addr(7), 8'h40, 0);
        do_cmd(20'h7_1234, 8'hA5, 1);
        do_cmd(rnd_addr(7), 8'h10, 1);
        do_cmd(20'h9_00FF, 8'h3C, 0);

        // Write protect on boot block (R8)
        wp_n = 1'b0;
        do_cmd(rnd_addr(0), 8'h40, 0);
        do_cmd(20'h0_0010, 8'h11, 0);
        do_cmd(rnd_addr(1), 8'h20, 0);
        do_cmd(20'h1_0000, 8'hD0, 0);
        do_cmd(rnd_addr(0), 8'h30, 0);   // chip erase refused (R4)
        do_cmd(rnd_addr(0), 8'hD0, 0);
        do_cmd(rnd_addr(0), 8'h50, 0);   // clear errors (R2)
        wp_n = 1'b1;
        do_cmd(rnd_addr(0), 8'h40, 0);
        do_cmd(20'h0_0010, 8'h11, 0);
        do_cmd(rnd_addr(0), 8'h30, 1);   // chip erase now allowed (R4)
        do_cmd(rnd_addr(0), 8'hD0, 1);

        // Block lock, abort, suspend/resume (R6, R10, R5)
        do_cmd(rnd_addr(3), 8'h60, 0);
        do_cmd(20'h3_0000, 8'h01, 0);
        do_cmd(rnd_addr(3), 8'h20, 0);
        do_cmd(20'h3_0040, 8'hD0, 0);    // locked main block
        do_cmd(rnd_addr(3), 8'h20, 0);
        do_cmd(rnd_addr(3), 8'hFF, 0);   // invalid confirm (R10)
        do_cmd(rnd_addr(3), 8'h90, 0);   // decoded as first cycle
        do_cmd(rnd_addr(3), 8'hB0, 0);
        do_cmd(rnd_addr(3), 8'hD0, 0);
        do_cmd(rnd_addr(3), 8'h60, 0);
        do_cmd(rnd_addr(3), 8'hD0, 0);   // clear all
        do_cmd(rnd_addr(3), 8'h40, 0);
        do_cmd(20'h3_0001, 8'h77, 0);

        // Master lock (R7)
        do_cmd(rnd_addr(4), 8'h60, 0);
        do_cmd(rnd_addr(4), 8'h01, 0);
        do_cmd(rnd_addr(4), 8'h60, 0);
        do_cmd(rnd_addr(4), 8'hF1, 0);
        do_cmd(rnd_addr(4), 8'h60, 0);
        do_cmd(rnd_addr(4), 8'hD0, 0);   // refused, block 4 stays locked
        do_cmd(rnd_addr(4), 8'h60, 0);
        do_cmd(rnd_addr(6), 8'h01, 1);   // refused
        do_cmd(rnd_addr(4), 8'h40, 0);
        do_cmd(rnd_addr(4), 8'h5A, 0);   // still locked: master never cleared

        // Constrained random
        for (int it = 0; it < 800; it++) begin
            logic [7:0] d;
            int sel;
            if (it % 200 == 0) do_reset();
            if ($urandom % 8 == 0) wp_n = 1'($urandom);
            eng_busy = 1'($urandom);
            sel = int'($urandom % 14);
            if (m_pend != 0) begin
                case (sel % 7)
                    0, 1, 2: d = 8'hD0;
                    3, 4:    d = 8'h01;
                    5:       d = ($urandom % 6 == 0) ? 8'hF1 : 8'($urandom);
                    default: d = 8'($urandom);
                endcase
            end else begin
                case (sel)
                    0: d = 8'hFF;  1: d = 8'h90;  2: d = 8'h70;  3: d = 8'h50;
                    4: d = 8'h20;  5: d = 8'h30;  6: d = 8'h40;  7: d = 8'h10;
                    8: d = 8'h60;  9: d = 8'hB0; 10: d = 8'hD0; 11: d = 8'h40;
                    12: d = 8'h20;
                    default: d = 8'($urandom);
                endcase
            end
            do_cmd(rnd_addr(int'($urandom % 16)), d, 1'($urandom));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule